// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block predicts, for a load or a store entering the machine, whether it must wait for an older store that is still in flight. Instruction addresses are grouped into store sets. Each address is hashed into an identifier table, and the entry there names a set. A second table records, for each set, the sequence number of the youngest store of that set fetched so far. A consumer asks about an address and gets back either that sequence number, meaning "wait for this store", or zero, meaning "independent".

Sets form when ordering violations are reported. Stores enter the tracking when they are inserted. They leave it when they issue or when their thread is squashed. The prediction then ends when the recorded store has issued or has been flushed. After a configurable number of inserted memory operations, the whole predictor wipes itself so that stale sets do not accumulate. Only one update is applied in any cycle, and a fixed priority picks it.

Top module: `store_set_pred`

## Requirements
- R1: After reset every table entry is invalid, and the check output is zero for every address.
- R2: The check output is the youngest recorded store sequence number of the set named by identifier-table entry `chkPc & (SSIT_N-1)`. It is zero when either that identifier entry or the set's store entry is invalid. The output is purely combinational from the current state.
- R3: A violation where neither address has a valid identifier entry gives both entries the set number `((loadPc ^ (loadPc >> 10)) % LFST_N)` and marks them valid.
- R4: A violation where only one of the two entries is valid copies that entry's set number into the other. When both are valid, both take the smaller of the two set numbers.
- R5: A store insert whose identifier entry is valid writes its sequence number into its set's store entry, marks that entry valid and adds the store to the pending list. A store insert whose identifier entry is invalid changes no prediction.
- R6: An issued store whose set's store entry still holds its sequence number invalidates that entry and leaves the pending list. An issued store whose number differs changes nothing, and an issued load changes nothing.
- R7: A squash for a thread removes every pending store of that thread whose sequence number is strictly greater than the given one. Any set entry still holding a removed store's number is invalidated. Other threads' stores and the same or older numbers are kept.
- R8: The pending list holds PEND_N stores. A store insert that finds it full evicts the entry with the smallest sequence number. The evicted store no longer takes part in squashes.
- R9: Every insert, whether load or store, advances a counter. The insert that would bring the counter to CLEAR_PERIOD instead wipes both tables and the pending list, resets the counter and is itself discarded.
- R10: The clear input wipes both tables, the pending list and the insert counter.
- R11: When several requests arrive in one cycle, only the highest of clear, squash, violation, issue, insert is applied, and the rest are dropped without effect, including on the counter.
- R12: An update requested in a cycle becomes visible on the check output right after the rising edge that ends the cycle, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clrReq | input | 1 | Wipe the whole predictor |
| sqValid | input | 1 | Squash request |
| sqThread | input | THR_W | Thread being squashed |
| sqSeq | input | SEQ_W | Stores younger than this number are removed |
| violValid | input | 1 | Ordering violation report |
| violStorePc | input | PC_W | Address of the older store |
| violLoadPc | input | PC_W | Address of the younger load |
| issValid | input | 1 | Issue notification |
| issIsStore | input | 1 | Issued instruction is a store |
| issPc | input | PC_W | Address of the issued instruction |
| issSeq | input | SEQ_W | Sequence number of the issued instruction |
| insValid | input | 1 | Insert notification |
| insIsStore | input | 1 | Inserted instruction is a store |
| insPc | input | PC_W | Address of the inserted instruction |
| insSeq | input | SEQ_W | Sequence number of the inserted instruction |
| insThread | input | THR_W | Thread of the inserted instruction |
| chkPc | input | PC_W | Address to look up |
| chkSeq | output | SEQ_W | Store to wait for, zero when independent |

## Verification
Every update takes effect at exactly one rising edge, and the lookup is combinational. A result is therefore due in the low phase that follows the edge at which its request was sampled. The bench drives requests on the falling edge, steps one rising edge, and only then sweeps every identifier index through the lookup port. One directed case also samples before that edge, to show the old answer still holds. A bench-side model follows the same one-operation-per-cycle priority, so a prediction is always compared against the state after the edge and never against a half-applied update.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // One-hot-or-idle update strobes issued by the control to the datapath
  typedef struct packed {
    logic wipe;      // clear request or periodic wipe
    logic squash;
    logic viol;
    logic issue;
    logic insStore;  // store insert that survives the period check
  } ssp_strobe_t;

endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int CLEAR_PERIOD = 250000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clrReq,
  input  logic        sqValid,
  input  logic        violValid,
  input  logic        issValid,
  input  logic        insValid,
  input  logic        insIsStore,
  output ssp_strobe_t st
);

  localparam int CNT_W = $clog2(CLEAR_PERIOD + 1);

  logic [CNT_W-1:0] opCount;
  logic selSquash, selViol, selIssue, selInsert, periodHit;

  // fixed priority: clear > squash > violation > issue > insert
  always_comb begin
    selSquash = sqValid && !clrReq;
    selViol   = violValid && !clrReq && !sqValid;
    selIssue  = issValid && !clrReq && !sqValid && !violValid;
    selInsert = insValid && !clrReq && !sqValid && !violValid && !issValid;
    periodHit = selInsert && (opCount == CNT_W'(CLEAR_PERIOD - 1));
  end

  always_comb begin
    st          = '0;
    st.wipe     = clrReq || periodHit;
    st.squash   = selSquash;
    st.viol     = selViol;
    st.issue    = selIssue;
    st.insStore = selInsert && insIsStore && !periodHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          opCount <= '0;
    else if (st.wipe)    opCount <= '0;
    else if (selInsert)  opCount <= opCount + 1'b1;
  end

endmodule

// File: rtl/ssp_pend_list.sv
module ssp_pend_list
  import ssp_pkg::*;
#(
  parameter int SEQ_W  = 32,
  parameter int THR_W  = 2,
  parameter int SSID_W = 4,
  parameter int PEND_N = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  ssp_strobe_t                    st,
  input  logic [THR_W-1:0]               sqThread,
  input  logic [SEQ_W-1:0]               sqSeq,
  input  logic                           issStore,
  input  logic [SEQ_W-1:0]               issSeq,
  input  logic                           insEn,
  input  logic [SEQ_W-1:0]               insSeq,
  input  logic [SSID_W-1:0]              insIdx,
  input  logic [THR_W-1:0]               insThread,
  output logic [PEND_N-1:0]              sqKill,
  output logic [PEND_N-1:0][SEQ_W-1:0]   entSeq,
  output logic [PEND_N-1:0][SSID_W-1:0]  entIdx
);

  localparam int PEND_IW = (PEND_N > 1) ? $clog2(PEND_N) : 1;

  logic [PEND_N-1:0]             vld;
  logic [PEND_N-1:0][SEQ_W-1:0]  seqA;
  logic [PEND_N-1:0][SSID_W-1:0] idxA;
  logic [PEND_N-1:0][THR_W-1:0]  thrA;
  logic [PEND_N-1:0]             issKill;

  logic               freeFound;
  logic [PEND_IW-1:0] freeSlot, oldSlot, insSlot;
  logic [SEQ_W-1:0]   minSeq;

  // per-entry match vectors
  for (genvar g = 0; g < PEND_N; g++) begin : gMatch
    assign sqKill[g]  = vld[g] && (thrA[g] == sqThread) && (seqA[g] > sqSeq);
    assign issKill[g] = vld[g] && (seqA[g] == issSeq);
  end

  // slot choice: lowest free slot, else the oldest (smallest sequence number)
  always_comb begin
    freeFound = 1'b0;
    freeSlot  = '0;
    for (int i = 0; i < PEND_N; i++) begin
      if (!vld[i] && !freeFound) begin
        freeFound = 1'b1;
        freeSlot  = PEND_IW'(i);
      end
    end
    minSeq  = seqA[0];
    oldSlot = '0;
    for (int i = 1; i < PEND_N; i++) begin
      if (seqA[i] < minSeq) begin
        minSeq  = seqA[i];
        oldSlot = PEND_IW'(i);
      end
    end
    insSlot = freeFound ? freeSlot : oldSlot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vld <= '0;
    else if (st.wipe)   vld <= '0;
    else if (st.squash) vld <= vld & ~sqKill;
    else if (issStore)  vld <= vld & ~issKill;
    else if (insEn)     vld[insSlot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (insEn) begin
      seqA[insSlot] <= insSeq;
      idxA[insSlot] <= insIdx;
      thrA[insSlot] <= insThread;
    end
  end

  assign entSeq = seqA;
  assign entIdx = idxA;

endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int SEQ_W  = 32,
  parameter int THR_W  = 2,
  parameter int SSIT_N = 1024,
  parameter int LFST_N = 16,
  parameter int PEND_N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ssp_strobe_t       st,
  input  logic [THR_W-1:0]  sqThread,
  input  logic [SEQ_W-1:0]  sqSeq,
  input  logic [PC_W-1:0]   violStorePc,
  input  logic [PC_W-1:0]   violLoadPc,
  input  logic              issIsStore,
  input  logic [PC_W-1:0]   issPc,
  input  logic [SEQ_W-1:0]  issSeq,
  input  logic [PC_W-1:0]   insPc,
  input  logic [SEQ_W-1:0]  insSeq,
  input  logic [THR_W-1:0]  insThread,
  input  logic [PC_W-1:0]   chkPc,
  output logic [SEQ_W-1:0]  chkSeq
);

  localparam int SSIT_IW = $clog2(SSIT_N);
  localparam int SSID_W  = (LFST_N > 1) ? $clog2(LFST_N) : 1;

  // identifier table and per-set youngest-store table
  logic [SSIT_N-1:0]  ssitV;
  logic [SSID_W-1:0]  ssitId [SSIT_N];
  logic [LFST_N-1:0]  lfstV;
  logic [SEQ_W-1:0]   lfstSeq [LFST_N];

  function automatic logic [SSID_W-1:0] hashSet(input logic [PC_W-1:0] pc);
    logic [PC_W-1:0] folded;
    folded = pc ^ (pc >> 10);
    return SSID_W'(folded % PC_W'(LFST_N));
  endfunction

  // lookup
  logic [SSIT_IW-1:0] chkIdx;
  logic [SSID_W-1:0]  chkSet;
  assign chkIdx = chkPc[SSIT_IW-1:0];
  assign chkSet = ssitId[chkIdx];
  assign chkSeq = (ssitV[chkIdx] && lfstV[chkSet]) ? lfstSeq[chkSet] : '0;

  // violation merge
  logic [SSIT_IW-1:0] vsIdx, vlIdx;
  logic [SSID_W-1:0]  vsId, vlId, vId;
  logic               vsOk, vlOk;
  always_comb begin
    vsIdx = violStorePc[SSIT_IW-1:0];
    vlIdx = violLoadPc[SSIT_IW-1:0];
    vsOk  = ssitV[vsIdx];
    vlOk  = ssitV[vlIdx];
    vsId  = ssitId[vsIdx];
    vlId  = ssitId[vlIdx];
    unique case ({vsOk, vlOk})
      2'b00:   vId = hashSet(violLoadPc);
      2'b10:   vId = vsId;
      2'b01:   vId = vlId;
      default: vId = (vsId < vlId) ? vsId : vlId;
    endcase
  end

  // issue match
  logic [SSIT_IW-1:0] issIdx;
  logic [SSID_W-1:0]  issSet;
  logic               issHit, issStore;
  assign issIdx   = issPc[SSIT_IW-1:0];
  assign issSet   = ssitId[issIdx];
  assign issStore = st.issue && issIsStore;
  assign issHit   = issStore && ssitV[issIdx] && lfstV[issSet] && (lfstSeq[issSet] == issSeq);

  // insert
  logic [SSIT_IW-1:0] insIdx;
  logic [SSID_W-1:0]  insSet;
  logic               insEn;
  assign insIdx = insPc[SSIT_IW-1:0];
  assign insSet = ssitId[insIdx];
  assign insEn  = st.insStore && ssitV[insIdx];

  // pending stores
  logic [PEND_N-1:0]              sqKill;
  logic [PEND_N-1:0][SEQ_W-1:0]   entSeq;
  logic [PEND_N-1:0][SSID_W-1:0]  entIdx;

  ssp_pend_list #(
    .SEQ_W(SEQ_W), .THR_W(THR_W), .SSID_W(SSID_W), .PEND_N(PEND_N)
  ) u_pend (
    .clk(clk), .rst_n(rst_n), .st(st),
    .sqThread(sqThread), .sqSeq(sqSeq),
    .issStore(issStore), .issSeq(issSeq),
    .insEn(insEn), .insSeq(insSeq), .insIdx(insSet), .insThread(insThread),
    .sqKill(sqKill), .entSeq(entSeq), .entIdx(entIdx)
  );

  // valid bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssitV <= '0;
      lfstV <= '0;
    end else if (st.wipe) begin
      ssitV <= '0;
      lfstV <= '0;
    end else begin
      if (st.squash) begin
        for (int p = 0; p < PEND_N; p++) begin
          if (sqKill[p] && lfstV[entIdx[p]] && (lfstSeq[entIdx[p]] == entSeq[p]))
            lfstV[entIdx[p]] <= 1'b0;
        end
      end
      if (st.viol) begin
        ssitV[vsIdx] <= 1'b1;
        ssitV[vlIdx] <= 1'b1;
      end
      if (issHit) lfstV[issSet] <= 1'b0;
      if (insEn)  lfstV[insSet] <= 1'b1;
    end
  end

  // table contents
  always_ff @(posedge clk) begin
    if (st.viol) begin
      ssitId[vsIdx] <= vId;
      ssitId[vlIdx] <= vId;
    end
    if (insEn) lfstSeq[insSet] <= insSeq;
  end

  logic unusedPcHi;
  assign unusedPcHi = ^{chkPc[PC_W-1:SSIT_IW], violStorePc[PC_W-1:SSIT_IW],
                        issPc[PC_W-1:SSIT_IW], insPc[PC_W-1:SSIT_IW]};

endmodule

// File: rtl/store_set_pred.sv
module store_set_pred
  import ssp_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int SEQ_W        = 32,
  parameter int THR_W        = 2,
  parameter int SSIT_N       = 1024,
  parameter int LFST_N       = 16,
  parameter int PEND_N       = 16,
  parameter int CLEAR_PERIOD = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clrReq,
  input  logic              sqValid,
  input  logic [THR_W-1:0]  sqThread,
  input  logic [SEQ_W-1:0]  sqSeq,
  input  logic              violValid,
  input  logic [PC_W-1:0]   violStorePc,
  input  logic [PC_W-1:0]   violLoadPc,
  input  logic              issValid,
  input  logic              issIsStore,
  input  logic [PC_W-1:0]   issPc,
  input  logic [SEQ_W-1:0]  issSeq,
  input  logic              insValid,
  input  logic              insIsStore,
  input  logic [PC_W-1:0]   insPc,
  input  logic [SEQ_W-1:0]  insSeq,
  input  logic [THR_W-1:0]  insThread,
  input  logic [PC_W-1:0]   chkPc,
  output logic [SEQ_W-1:0]  chkSeq
);

  ssp_strobe_t st;

  ssp_ctrl #(.CLEAR_PERIOD(CLEAR_PERIOD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clrReq(clrReq), .sqValid(sqValid),
    .violValid(violValid), .issValid(issValid), .insValid(insValid),
    .insIsStore(insIsStore), .st(st)
  );

  ssp_datapath #(
    .PC_W(PC_W), .SEQ_W(SEQ_W), .THR_W(THR_W),
    .SSIT_N(SSIT_N), .LFST_N(LFST_N), .PEND_N(PEND_N)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st),
    .sqThread(sqThread), .sqSeq(sqSeq),
    .violStorePc(violStorePc), .violLoadPc(violLoadPc),
    .issIsStore(issIsStore), .issPc(issPc), .issSeq(issSeq),
    .insPc(insPc), .insSeq(insSeq), .insThread(insThread),
    .chkPc(chkPc), .chkSeq(chkSeq)
  );

endmodule

// File: rtl/store_set_pred_chk.sv
module store_set_pred_chk
  import ssp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int SEQ_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clrReq,
  input logic              sqValid,
  input logic              issValid,
  input logic              issIsStore,
  input logic [PC_W-1:0]   chkPc,
  input logic [SEQ_W-1:0]  chkSeq,
  input ssp_strobe_t       st
);

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clrReq |=> (chkSeq == '0)); // R10

  AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    st.wipe |=> (chkSeq == '0)); // R9

  AST_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    clrReq |-> !(st.squash || st.viol || st.issue || st.insStore)); // R11

  AST_SQUASH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sqValid && !clrReq) |-> (st.squash && !st.viol && !st.issue && !st.insStore)); // R11

  AST_LOAD_ISSUE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st.issue && issValid && !issIsStore) |=> (!$stable(chkPc) || $stable(chkSeq))); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(st.wipe || st.squash || st.viol || st.issue || st.insStore)
      |=> (!$stable(chkPc) || $stable(chkSeq))); // R12

endmodule

bind store_set_pred store_set_pred_chk #(.PC_W(PC_W), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clrReq(clrReq), .sqValid(sqValid),
  .issValid(issValid), .issIsStore(issIsStore),
  .chkPc(chkPc), .chkSeq(chkSeq), .st(st)
);

// File: tb/store_set_pred_test.sv
module store_set_pred_test;

  localparam int SN = 16;   // identifier entries
  localparam int LN = 8;    // set entries
  localparam int PN = 4;    // pending stores
  localparam int CP = 12;   // clear period

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clrReq = 0, sqValid = 0, violValid = 0, issValid = 0, issIsStore = 0;
  logic        insValid = 0, insIsStore = 0;
  logic [0:0]  sqThread = 0, insThread = 0;
  logic [31:0] sqSeq = 0, violStorePc = 0, violLoadPc = 0, issPc = 0, issSeq = 0;
  logic [31:0] insPc = 0, insSeq = 0, chkPc = 0;
  logic [31:0] chkSeq;

  int nTests = 0, nFail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  store_set_pred #(
    .PC_W(32), .SEQ_W(32), .THR_W(1), .SSIT_N(SN), .LFST_N(LN),
    .PEND_N(PN), .CLEAR_PERIOD(CP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .clrReq(clrReq),
    .sqValid(sqValid), .sqThread(sqThread), .sqSeq(sqSeq),
    .violValid(violValid), .violStorePc(violStorePc), .violLoadPc(violLoadPc),
    .issValid(issValid), .issIsStore(issIsStore), .issPc(issPc), .issSeq(issSeq),
    .insValid(insValid), .insIsStore(insIsStore), .insPc(insPc), .insSeq(insSeq),
    .insThread(insThread), .chkPc(chkPc), .chkSeq(chkSeq)
  );

  // ---------------- reference model ----------------
  logic        mSsitV [SN];
  int          mSsit  [SN];
  logic        mLfstV [LN];
  logic [31:0] mLfst  [LN];
  logic        pV [PN];
  logic [31:0] pSeq [PN];
  int          pIdx [PN];
  logic        pThr [PN];
  int          mCnt;

  function automatic int hashOf(logic [31:0] pc);
    return int'((pc ^ (pc >> 10)) % LN);
  endfunction

  function automatic logic [31:0] mCheck(logic [31:0] pc);
    int i = int'(pc % SN);
    if (mSsitV[i] && mLfstV[mSsit[i]]) return mLfst[mSsit[i]];
    return 0;
  endfunction

  task automatic mWipe();
    for (int i = 0; i < SN; i++) mSsitV[i] = 0;
    for (int i = 0; i < LN; i++) mLfstV[i] = 0;
    for (int i = 0; i < PN; i++) pV[i] = 0;
    mCnt = 0;
  endtask

  task automatic mApply();
    if (clrReq) mWipe();
    else if (sqValid) begin
      for (int p = 0; p < PN; p++)
        if (pV[p] && pThr[p] == sqThread[0] && pSeq[p] > sqSeq) begin
          pV[p] = 0;
          if (mLfstV[pIdx[p]] && mLfst[pIdx[p]] == pSeq[p]) mLfstV[pIdx[p]] = 0;
        end
    end else if (violValid) begin
      int s = int'(violStorePc % SN), l = int'(violLoadPc % SN), id;
      if (!mSsitV[s] && !mSsitV[l]) id = hashOf(violLoadPc);
      else if (!mSsitV[l]) id = mSsit[s];
      else if (!mSsitV[s]) id = mSsit[l];
      else id = (mSsit[s] < mSsit[l]) ? mSsit[s] : mSsit[l];
      mSsit[s] = id; mSsit[l] = id; mSsitV[s] = 1; mSsitV[l] = 1;
    end else if (issValid) begin
      if (issIsStore) begin
        int i = int'(issPc % SN);
        if (mSsitV[i] && mLfstV[mSsit[i]] && mLfst[mSsit[i]] == issSeq) mLfstV[mSsit[i]] = 0;
        for (int p = 0; p < PN; p++) if (pV[p] && pSeq[p] == issSeq) pV[p] = 0;
      end
    end else if (insValid) begin
      if (mCnt == CP - 1) mWipe();
      else begin
        int i = int'(insPc % SN);
        mCnt++;
        if (insIsStore && mSsitV[i]) begin
          int slot = -1;
          mLfst[mSsit[i]] = insSeq; mLfstV[mSsit[i]] = 1;
          for (int p = 0; p < PN; p++) if (!pV[p] && slot < 0) slot = p;
          if (slot < 0) begin
            slot = 0;
            for (int p = 1; p < PN; p++) if (pSeq[p] < pSeq[slot]) slot = p;
          end
          pV[slot] = 1; pSeq[slot] = insSeq; pIdx[slot] = mSsit[i]; pThr[slot] = insThread[0];
        end
      end
    end
  endtask

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkAt(input logic [31:0] pc, input logic [31:0] exp, input string tag);
    chkPc = pc;
    #2;
    check(tag, chkSeq, exp);
  endtask

  // called just after a falling edge with requests set
  task automatic step();
    @(posedge clk);
    mApply();
    @(negedge clk);
    clrReq = 0; sqValid = 0; violValid = 0; issValid = 0; insValid = 0;
  endtask

  task automatic opClr();
    clrReq = 1; step();
  endtask
  task automatic opViol(input logic [31:0] s, input logic [31:0] l);
    violValid = 1; violStorePc = s; violLoadPc = l; step();
  endtask
  task automatic opIns(input logic st, input logic [31:0] pc, input logic [31:0] sq, input logic th);
    insValid = 1; insIsStore = st; insPc = pc; insSeq = sq; insThread = th; step();
  endtask
  task automatic opIss(input logic st, input logic [31:0] pc, input logic [31:0] sq);
    issValid = 1; issIsStore = st; issPc = pc; issSeq = sq; step();
  endtask
  task automatic opSq(input logic th, input logic [31:0] sq);
    sqValid = 1; sqThread = th; sqSeq = sq; step();
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < SN; i++) begin
      logic [31:0] pc = (($urandom % 4) << 10) | i;
      chkAt(pc, mCheck(pc), tag);
      @(negedge clk);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 200000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] seqCtr;
    mWipe();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    sweep("R1 reset");

    // R3 / R5 / R12: fresh set from load hash, store insert
    opClr();
    opViol(32'h403, 32'hC05);               // hash(0xC05) = 6
    insValid = 1; insIsStore = 1; insPc = 32'h403; insSeq = 100; insThread = 0;
    chkPc = 32'h005; #5;
    check("R12 before edge", chkSeq, 0);
    step();
    chkAt(32'h005, 100, "R3 load side");
    chkAt(32'h403, 100, "R5 store side");
    chkAt(32'h007, 0, "R2 invalid entry");
    opIns(1, 32'h009, 101, 0);
    chkAt(32'h009, 0, "R5 invalid identifier");
    chkAt(32'h005, 100, "R5 untouched");

    // R6: issue
    opIss(0, 32'h403, 100);
    chkAt(32'h403, 100, "R6 load issue");
    opIss(1, 32'h403, 99);
    chkAt(32'h403, 100, "R6 other seq");
    opIss(1, 32'h403, 100);
    chkAt(32'h403, 0, "R6 matching store");

    // R4: merge rules
    opClr();
    opViol(32'h001, 32'h402);               // id 3
    opViol(32'h004, 32'h402);               // copy 3
    opIns(1, 32'h004, 200, 0);
    chkAt(32'h001, 200, "R4 copy a");
    chkAt(32'h002, 200, "R4 copy b");
    opViol(32'h006, 32'h007);               // id 7
    opViol(32'h006, 32'h001);               // min(7,3)=3
    chkAt(32'h006, 200, "R4 min merge");
    chkAt(32'h007, 0, "R4 other keeps 7");

    // R7: per-thread squash
    opClr();
    opViol(32'h000, 32'h001);               // id 1
    opIns(1, 32'h000, 10, 0);
    opIns(1, 32'h000, 11, 1);
    opSq(0, 5);
    chkAt(32'h000, 11, "R7 other thread kept");
    opSq(1, 11);
    chkAt(32'h000, 11, "R7 equal seq kept");
    opSq(1, 10);
    chkAt(32'h000, 0, "R7 younger removed");

    // R8: full list evicts oldest
    opClr();
    opViol(32'h000, 32'h001);               // id 1
    opViol(32'h002, 32'h003);               // id 3
    opIns(1, 32'h000, 20, 0);
    for (int k = 21; k <= 24; k++) opIns(1, 32'h002, k, 0);
    opSq(0, 19);
    chkAt(32'h000, 20, "R8 evicted survives squash");
    chkAt(32'h002, 0, "R8 squashed set");

    // R9: periodic wipe
    opClr();
    opViol(32'h000, 32'h001);
    for (int k = 30; k <= 39; k++) opIns(1, 32'h000, k, 0);
    opIns(0, 32'h000, 0, 0);                // 11th insert
    chkAt(32'h000, 39, "R9 before period");
    opIns(1, 32'h000, 40, 0);               // 12th insert wipes
    chkAt(32'h000, 0, "R9 wiped");
    chkAt(32'h001, 0, "R9 wiped identifiers");
    opViol(32'h000, 32'h001);
    opIns(1, 32'h000, 50, 0);
    chkAt(32'h000, 50, "R9 counter restarted");

    // R11 / R10: priority
    opClr();
    opViol(32'h000, 32'h001);
    opIns(1, 32'h000, 60, 0);
    issValid = 1; issIsStore = 1; issPc = 32'h000; issSeq = 60;
    insValid = 1; insIsStore = 1; insPc = 32'h000; insSeq = 61; insThread = 0;
    step();
    chkAt(32'h000, 0, "R11 issue beats insert");
    sqValid = 1; sqThread = 0; sqSeq = 0;
    violValid = 1; violStorePc = 32'h005; violLoadPc = 32'h006;
    step();
    opIns(1, 32'h005, 70, 0);
    chkAt(32'h005, 0, "R11 squash beats violation");
    opIns(1, 32'h000, 75, 0);
    chkAt(32'h000, 75, "R11 setup");
    clrReq = 1; insValid = 1; insIsStore = 1; insPc = 32'h000; insSeq = 80;
    step();
    sweep("R10 clear beats insert");

    // R2 / R11: mixed random sweep against model
    seqCtr = 1000;
    for (int n = 0; n < 300; n++) begin
      clrReq    = ($urandom % 40) == 0;
      sqValid   = ($urandom % 10) == 0;
      violValid = ($urandom % 4) == 0;
      issValid  = ($urandom % 4) == 0;
      insValid  = ($urandom % 2) == 0;
      sqThread = 1'($urandom % 2);
      sqSeq = seqCtr - ($urandom % 6);
      violStorePc = (($urandom % 4) << 10) | ($urandom % SN);
      violLoadPc  = (($urandom % 4) << 10) | ($urandom % SN);
      issIsStore = ($urandom % 4) != 0;
      issPc  = (($urandom % 4) << 10) | ($urandom % SN);
      issSeq = seqCtr - ($urandom % 4);
      insIsStore = ($urandom % 4) != 0;
      insPc  = (($urandom % 4) << 10) | ($urandom % SN);
      insSeq = seqCtr + 1;
      insThread = 1'($urandom % 2);
      if (insValid && insIsStore) seqCtr = seqCtr + 1;
      step();
      sweep("R2 R11 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule